// File: doc/BRIEF.md
# Byte-Serial SPI Master Shift Engine

This block is the shifting core of a byte-oriented SPI master. A byte source (a transmit FIFO outside the block) offers bytes through a valid/pop pair. The engine serialises each byte onto the data-out line, captures the data-in line on the opposite clock edge, and hands each completed byte to a receive FIFO outside the block through a push strobe. Serial clock timing comes from an external enable pulse that arrives at twice the serial clock rate. Each pulse moves the serial clock by one edge.

Software programs a 32-bit configuration word. The word holds the clock mode, the bit order, chip-select routing and polarity, manual chip-select control and a receive-discard option. Setting the top bit of the word starts a burst. Two 24-bit length inputs control the burst. One gives the total number of bytes to clock. The other gives how many of them come from the byte source. The remaining bytes are sent as zero filler. When the last byte has been clocked, the engine sets a sticky completion flag, which stays set until it is cleared.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, sclk is 0, every cs_out line is 1, done_flag is 0, busy is 0, and neither tx_pop nor rx_push is asserted.
- R2: Outside a byte, sclk rests at the level of config bit 1. Each byte takes 16 sclk edges. With config bit 0 clear, data is sampled on the first edge of each bit and changed on the second. With it set, data is changed on the first edge and sampled on the second.
- R3: With config bit 12 clear, bit 7 of each byte goes out and comes in first. With it set, bit 0 goes first.
- R4: A burst clocks exactly burst_len bytes. The first tx_len of them are popped from the byte source, one pop each. Any later byte goes out as 0x00 without a pop.
- R5: With config bit 8 set, rx_push is never asserted. Otherwise one push carries each received byte.
- R6: done_flag is set when a burst ends and stays set until done_clr. If the set and done_clr fall in the same cycle, the set wins.
- R7: Writing the configuration with bit 31 set while idle starts a burst and raises busy. busy falls when the burst ends. A burst_len of 0 sets done_flag on the write cycle's edge, with no sclk edge.
- R8: In automatic mode (config bit 6 clear), the line chosen by config bits 5:4 sits at its active level for the whole burst and is inactive otherwise. The active level is given by config bit 2 (0 means low, 1 means high). All other lines stay inactive.
- R9: With config bit 6 set, the chosen chip-select line is driven to the level of config bit 7, whether or not a burst is running.
- R10: When a byte is due from the source and tx_avail is low, the engine waits with sclk unchanged until a byte is offered.
- R11: Configuration writes made while busy are ignored, including their bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_en | input | 1 | Edge-rate enable pulse, twice the serial clock rate |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| burst_len | input | 24 | Total bytes to clock, sampled at start |
| tx_len | input | 24 | Bytes to take from the source, sampled at start |
| done_clr | input | 1 | Clears the completion flag |
| busy | output | 1 | Burst in progress |
| done_flag | output | 1 | Sticky completion flag |
| tx_avail | input | 1 | Byte source has a byte |
| tx_byte | input | 8 | Byte offered by the source |
| tx_pop | output | 1 | Takes the offered byte |
| rx_push | output | 1 | Received byte strobe |
| rx_byte | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 4 | Chip-select lines |

## Verification
The completion flag has a set source (the end of a burst) and a clear source (done_clr), and both can act in the same cycle. The bench provokes this with a zero-length burst, because that burst sets the flag on the very edge of the start write. It drives done_clr during that same write cycle and expects the flag high afterwards. A later pulse of done_clr alone must then bring the flag low.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int CFG_W    = 32;
    localparam int B_CPHA   = 0;
    localparam int B_CPOL   = 1;
    localparam int B_CSPOL  = 2;
    localparam int B_CSIDX  = 4;
    localparam int B_CSMAN  = 6;
    localparam int B_CSLVL  = 7;
    localparam int B_DISC   = 8;
    localparam int B_LSB    = 12;
    localparam int B_GO     = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT
    } eng_state_t;

    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic       cs_pol;
        logic [1:0] cs_idx;
        logic       cs_man;
        logic       cs_lvl;
        logic       discard;
        logic       lsb_first;
    } eng_cfg_t;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int WORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WORD-1:0] load_byte,
    input  logic            present,
    input  logic            sample,
    input  logic            lsb_first,
    input  logic            miso,
    output logic            mosi,
    output logic [WORD-1:0] rx_cur,
    output logic [WORD-1:0] rx_next
);

    typedef struct packed {
        logic [WORD-1:0] tx;
        logic [WORD-1:0] rx;
        logic            mosi;
    } shf_t;

    shf_t s_q, s_d;
    logic [WORD-1:0] base;

    always_comb begin
        rx_next = lsb_first ? {miso, s_q.rx[WORD-1:1]} : {s_q.rx[WORD-2:0], miso};
        base    = load ? load_byte : s_q.tx;
        s_d     = s_q;
        s_d.tx  = base;
        if (present) begin
            s_d.mosi = lsb_first ? base[0] : base[WORD-1];
            s_d.tx   = lsb_first ? (base >> 1) : (base << 1);
        end
        if (sample) begin
            s_d.rx = rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mosi   = s_q.mosi;
    assign rx_cur = s_q.rx;

endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
    parameter int N_CS  = 4,
    localparam int IDX_W = (N_CS > 1) ? $clog2(N_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel,
    input  logic             act_high,
    input  logic             manual,
    input  logic             man_lvl,
    input  logic             burst_on,
    output logic [N_CS-1:0]  cs_out
);

    generate
        for (genvar i = 0; i < N_CS; i++) begin : g_line
            always_comb begin
                if (sel == IDX_W'(i)) begin
                    if (manual)        cs_out[i] = man_lvl;
                    else if (burst_on) cs_out[i] = act_high;
                    else               cs_out[i] = ~act_high;
                end else begin
                    cs_out[i] = ~act_high;
                end
            end
        end
    endgenerate

    // R8: automatic mode never asserts more than one line
    assert_single_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !manual |-> $onehot0(cs_out ^ {N_CS{~act_high}}));

    // R8: automatic mode with no burst leaves every line inactive
    assert_idle_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && !burst_on) |-> (cs_out == {N_CS{~act_high}}));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int WORD  = 8,
    parameter int CNT_W = 24,
    parameter int N_CS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_en,
    input  logic             cfg_wr,
    input  logic [31:0]      cfg_wdata,
    input  logic [CNT_W-1:0] burst_len,
    input  logic [CNT_W-1:0] tx_len,
    input  logic             done_clr,
    output logic             busy,
    output logic             done_flag,
    input  logic             tx_avail,
    input  logic [WORD-1:0]  tx_byte,
    output logic             tx_pop,
    output logic             rx_push,
    output logic [WORD-1:0]  rx_byte,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [N_CS-1:0]  cs_out
);

    localparam int HALF_W = $clog2(2 * WORD);
    localparam logic [HALF_W-1:0] HALF_LAST = HALF_W'(2 * WORD - 1);

    typedef struct packed {
        eng_state_t        state;
        eng_cfg_t          cfg;
        logic [HALF_W-1:0] half;
        logic [CNT_W-1:0]  left;
        logic [CNT_W-1:0]  tx_left;
        logic              sclk;
        logic              done;
    } eng_t;

    eng_t r_q, r_d;

    logic            ld, pres, samp, need_tx, lead;
    logic [WORD-1:0] rx_cur, rx_next;

    always_comb begin
        r_d     = r_q;
        tx_pop  = 1'b0;
        rx_push = 1'b0;
        rx_byte = rx_cur;
        ld      = 1'b0;
        pres    = 1'b0;
        samp    = 1'b0;
        need_tx = (r_q.tx_left != '0);
        lead    = ~r_q.half[0];
        if (done_clr) r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (cfg_wr) begin
                    r_d.cfg.cpha      = cfg_wdata[B_CPHA];
                    r_d.cfg.cpol      = cfg_wdata[B_CPOL];
                    r_d.cfg.cs_pol    = cfg_wdata[B_CSPOL];
                    r_d.cfg.cs_idx    = cfg_wdata[B_CSIDX +: 2];
                    r_d.cfg.cs_man    = cfg_wdata[B_CSMAN];
                    r_d.cfg.cs_lvl    = cfg_wdata[B_CSLVL];
                    r_d.cfg.discard   = cfg_wdata[B_DISC];
                    r_d.cfg.lsb_first = cfg_wdata[B_LSB];
                    r_d.sclk          = cfg_wdata[B_CPOL];
                    if (cfg_wdata[B_GO]) begin
                        if (burst_len == '0) begin
                            r_d.done = 1'b1;
                        end else begin
                            r_d.state   = ST_LOAD;
                            r_d.left    = burst_len;
                            r_d.tx_left = tx_len;
                        end
                    end
                end
            end
            ST_LOAD: begin
                if (!need_tx || tx_avail) begin
                    ld        = 1'b1;
                    tx_pop    = need_tx;
                    pres      = ~r_q.cfg.cpha;
                    r_d.half  = '0;
                    r_d.state = ST_SHIFT;
                    if (need_tx) r_d.tx_left = r_q.tx_left - 1'b1;
                end
            end
            ST_SHIFT: begin
                if (sclk_en) begin
                    r_d.sclk = ~r_q.sclk;
                    r_d.half = r_q.half + 1'b1;
                    samp     = r_q.cfg.cpha ? ~lead : lead;
                    pres     = r_q.cfg.cpha ? lead : (~lead && (r_q.half != HALF_LAST));
                    if (r_q.half == HALF_LAST) begin
                        rx_push = ~r_q.cfg.discard;
                        rx_byte = r_q.cfg.cpha ? rx_next : rx_cur;
                        if (r_q.left == CNT_W'(1)) begin
                            r_d.state = ST_IDLE;
                            r_d.left  = '0;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.left  = r_q.left - 1'b1;
                            r_d.state = ST_LOAD;
                        end
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    spi_byte_shifter #(.WORD(WORD)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld),
        .load_byte (need_tx ? tx_byte : '0),
        .present   (pres),
        .sample    (samp),
        .lsb_first (r_q.cfg.lsb_first),
        .miso      (miso),
        .mosi      (mosi),
        .rx_cur    (rx_cur),
        .rx_next   (rx_next)
    );

    spi_cs_drive #(.N_CS(N_CS)) u_cs (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (r_q.cfg.cs_idx),
        .act_high (r_q.cfg.cs_pol),
        .manual   (r_q.cfg.cs_man),
        .man_lvl  (r_q.cfg.cs_lvl),
        .burst_on (busy),
        .cs_out   (cs_out)
    );

    assign busy      = (r_q.state != ST_IDLE);
    assign done_flag = r_q.done;
    assign sclk      = r_q.sclk;

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg_wdata[30:13], cfg_wdata[11:9], cfg_wdata[3]};

    // R2: between bytes the serial clock rests at the polarity level
    assert_sclk_rest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_SHIFT) |-> (sclk == r_q.cfg.cpol));

    // R4: never pops once the source quota is used up
    assert_pop_quota_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (r_q.tx_left != '0));

    // R10: never pops from an empty source
    assert_pop_avail_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_avail);

    // R5: discard mode keeps the receive side silent
    assert_no_push_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !r_q.cfg.discard);

    // R6 and R7: the flag rises only as the engine goes idle
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> !busy);

    // R11: configuration holds while a burst runs
    assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(r_q.cfg));

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {lsb,disc,spol,cpol,cpha,-,idx[1:0]} burst xmit seed
    localparam logic [31:0] VEC [NVEC] = '{
        32'h00_03_03_A5,
        32'h11_02_02_3C,
        32'hAA_03_03_81,
        32'h9B_02_02_5E,
        32'h20_04_02_11,
        32'h49_03_03_C7
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_en;
    logic cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [23:0] burst_len = '0;
    logic [23:0] tx_len = '0;
    logic done_clr = 1'b0;
    logic busy, done_flag, tx_avail, tx_pop, rx_push, sclk, mosi, miso;
    logic [7:0] tx_byte, rx_byte;
    logic [3:0] cs_out;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [7:0] txq [0:15];
    logic [7:0] rxq [0:15];
    logic [7:0] monq [0:15];
    int tx_n = 0;
    int tx_i, rx_n, pop_n, mon_n, mon_bits, edge_n;
    logic [7:0] mon_sr;
    logic prev_sclk;
    logic mon_cpol = 1'b0;
    logic mon_cpha = 1'b0;
    logic clr_cnt = 1'b0;
    logic [1:0] en_div;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .burst_len(burst_len), .tx_len(tx_len),
        .done_clr(done_clr), .busy(busy), .done_flag(done_flag),
        .tx_avail(tx_avail), .tx_byte(tx_byte), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_byte(rx_byte), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_out(cs_out)
    );

    assign miso     = mosi;
    assign tx_avail = (tx_i < tx_n);
    assign tx_byte  = txq[tx_i[3:0]];
    assign sclk_en  = en_div[0];

    always @(posedge clk) begin
        if (!rst_n) en_div <= 2'd0;
        else        en_div <= en_div + 2'd1;
    end

    always @(posedge clk) begin
        if (clr_cnt) begin
            tx_i = 0; rx_n = 0; pop_n = 0; mon_n = 0; mon_bits = 0;
            edge_n = 0; mon_sr = 8'h00; prev_sclk = sclk;
        end else begin
            if (tx_pop) begin tx_i = tx_i + 1; pop_n = pop_n + 1; end
            if (rx_push && rx_n < 16) begin rxq[rx_n] = rx_byte; rx_n = rx_n + 1; end
            if (sclk !== prev_sclk) begin
                edge_n = edge_n + 1;
                if ((sclk != mon_cpol) ^ mon_cpha) begin
                    mon_sr = {mon_sr[6:0], mosi};
                    mon_bits = mon_bits + 1;
                    if (mon_bits == 8) begin
                        if (mon_n < 16) monq[mon_n] = mon_sr;
                        mon_n = mon_n + 1;
                        mon_bits = 0;
                    end
                end
            end
            prev_sclk = sclk;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] o;
        for (int k = 0; k < 8; k++) o[k] = b[7-k];
        return o;
    endfunction

    task automatic write_cfg(input logic [31:0] w, input logic clr);
        cfg_wdata = w; cfg_wr = 1'b1; done_clr = clr;
        @(negedge clk);
        cfg_wr = 1'b0; done_clr = 1'b0;
    endtask

    task automatic clear_counts();
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
    endtask

    task automatic wait_done();
        for (int k = 0; k < 3000 && !done_flag; k++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) txq[k] = 8'h00;
        clr_cnt = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(cs_out == 4'hF, "R1 cs_out", cs_out, 4'hF);
        check(!done_flag && !busy, "R1 flags", {done_flag, busy}, 0);
        check(!tx_pop && !rx_push, "R1 strobes", {tx_pop, rx_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;

        for (int v = 0; v < NVEC; v++) begin
            logic lsb, disc, spol, cpol, cpha;
            logic [1:0] idx;
            int bl, xl;
            logic [7:0] seed, b;
            logic [31:0] cw;
            logic [3:0] cs_exp;
            lsb = VEC[v][31]; disc = VEC[v][30]; spol = VEC[v][29];
            cpol = VEC[v][28]; cpha = VEC[v][27]; idx = VEC[v][25:24];
            bl = int'(VEC[v][23:16]); xl = int'(VEC[v][15:8]); seed = VEC[v][7:0];
            cw = {19'd0, lsb, 3'd0, disc, 2'd0, idx, 1'b0, spol, cpol, cpha};
            for (int k = 0; k < 16; k++) txq[k] = seed + 8'(k * 29);
            tx_n = xl; burst_len = 24'(bl); tx_len = 24'(xl);
            write_cfg(cw, 1'b0);
            @(negedge clk);
            mon_cpol = cpol; mon_cpha = cpha;
            clear_counts();
            check(sclk == cpol, "R2 idle level", sclk, cpol);
            write_cfg(cw | 32'h8000_0000, 1'b0);
            cs_exp = {4{~spol}};
            cs_exp[idx] = spol;
            check(busy, "R7 busy after start", busy, 1);
            check(cs_out == cs_exp, "R8 cs during burst", cs_out, cs_exp);
            wait_done();
            @(negedge clk);
            check(done_flag && !busy, "R6 done at end", {done_flag, busy}, 2);
            check(sclk == cpol, "R2 rest level after", sclk, cpol);
            check(cs_out == {4{~spol}}, "R8 cs released", cs_out, {4{~spol}});
            check(edge_n == 16 * bl, "R2 edge count", edge_n, 16 * bl);
            check(pop_n == xl, "R4 pop count", pop_n, xl);
            check(rx_n == (disc ? 0 : bl), "R5 push count", rx_n, disc ? 0 : bl);
            check(mon_n == bl, "R3 wire bytes", mon_n, bl);
            for (int k = 0; k < bl; k++) begin
                b = (k < xl) ? txq[k] : 8'h00;
                check(monq[k] == (lsb ? rev8(b) : b), "R3 wire order", monq[k], lsb ? rev8(b) : b);
                if (!disc)
                    check(rxq[k] == b, "R4 rx byte", rxq[k], b);
            end
            pulse_clr();
            check(!done_flag, "R6 cleared", done_flag, 0);
        end

        // R7/R6: zero-length burst with a simultaneous clear
        mon_cpol = 1'b0; mon_cpha = 1'b0;
        write_cfg(32'h0, 1'b0);
        clear_counts();
        burst_len = 24'd0; tx_len = 24'd0;
        write_cfg(32'h8000_0000, 1'b1);
        check(done_flag, "R6 set beats clear", done_flag, 1);
        check(!busy, "R7 zero burst idle", busy, 0);
        repeat (4) @(negedge clk);
        check(edge_n == 0, "R7 zero burst no sclk", edge_n, 0);
        pulse_clr();
        check(!done_flag, "R6 clear alone", done_flag, 0);

        // R9: manual chip select on line 2
        write_cfg(32'h0000_0060, 1'b0);
        check(cs_out == 4'b1011, "R9 manual low", cs_out, 4'hB);
        write_cfg(32'h0000_00E0, 1'b0);
        check(cs_out == 4'hF, "R9 manual high", cs_out, 4'hF);

        // R10/R11: empty source stalls; writes while busy ignored
        write_cfg(32'h0, 1'b0);
        clear_counts();
        txq[0] = 8'h6B; tx_n = 0;
        burst_len = 24'd1; tx_len = 24'd1;
        write_cfg(32'h8000_0000, 1'b0);
        repeat (20) @(negedge clk);
        check(edge_n == 0 && busy, "R10 stall", edge_n, 0);
        write_cfg(32'h8000_0002, 1'b0);
        check(sclk == 1'b0, "R11 write ignored", sclk, 0);
        tx_n = 1;
        wait_done();
        @(negedge clk);
        check(rx_n == 1 && rxq[0] == 8'h6B, "R10 byte after stall", rxq[0], 8'h6B);
        check(sclk == 1'b0 && edge_n == 16, "R11 mode kept", edge_n, 16);
        pulse_clr();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule